// File: doc/BRIEF.md
# Pipeline Advance Controller

This block decides, every cycle, which stages of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) may latch new work. Each stage can raise a freeze request. The latest stage that asks sets the freeze boundary. That stage and every stage ahead of it hold their contents. The stage just behind the boundary receives a NOP bubble in place of the frozen stage's output. Stages past the boundary keep advancing, so the bubble drains normally.

The block also owns the fetch program counter. An active-low reset loads all ones, so the first advance wraps to address zero. Each advancing fetch cycle adds one, unless decode has supplied a redirect target. A redirect that arrives while fetch is frozen is kept in a one-entry holding register and applied on the next fetch advance. The redirect input is a plain valid/target pair with no ready. It is accepted in every cycle, so the block never back-pressures decode. Hazard detection sits outside this block.

Top module: `pipe_adv_ctl`

## Requirements
- R1: With no stall request, all five stage enables are high and no bubble bit is set.
- R2: When stage k requests a stall (bit 0 fetch, 1 decode, 2 execute, 3 memory, 4 writeback), the enables of stage k and of every lower-numbered stage are low in that same cycle.
- R3: Every stage numbered above the highest requesting stage keeps its enable high.
- R4: The bubble bit with index b+1 is high exactly when b is the highest requesting stage and b is below 4. Bit 0 is never set, and at most one bubble bit is high.
- R5: While rst_n is low, fetch_pc is 0xFFFF and no redirect is held.
- R6: On a fetch-advancing edge with no new or held redirect, fetch_pc increments by one modulo 2^16, so 0xFFFF wraps to 0x0000.
- R7: On a fetch-advancing edge with redirect_valid high, fetch_pc loads redirect_pc.
- R8: A redirect given while fetch is held is kept, and fetch_pc loads its target on the next fetch-advancing edge.
- R9: While fetch is held, fetch_pc does not change.
- R10: A redirect given while another is already held replaces the held target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_req | input | 5 | Per-stage freeze requests, bit 0 = fetch |
| redirect_valid | input | 1 | Decode supplies a taken jump/branch target |
| redirect_pc | input | 16 | Redirect target address |
| stage_en | output | 5 | Per-stage advance enables |
| bubble_ins | output | 5 | Insert a NOP into this stage this cycle |
| fetch_pc | output | 16 | Current fetch address |

## Verification
Two functions can fall in the same cycle: a decode redirect and a fetch freeze caused by a stall at some later stage. The bench provokes this by raising a redirect while any stall bit is set. It does so once with a single redirect and once with two back-to-back redirects during the freeze. The redirect must not show in fetch_pc while the freeze lasts. The newest target must appear on the first edge at which fetch advances. A long pseudo-random mix of stalls and redirects is compared cycle by cycle against an arithmetic model of the PC. All 32 stall patterns are swept against the highest-set-bit rule for enables and bubbles.

// File: rtl/pipe_adv_pkg.sv
package pipe_adv_pkg;
  localparam int STAGES   = 5;
  localparam int ADDR_W   = 16;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_MEM    = 3'd3,
    ST_WB     = 3'd4
  } stage_e;
endpackage

// File: rtl/adv_stall_boundary.sv
module adv_stall_boundary #(
  parameter int N = pipe_adv_pkg::STAGES
) (
  input  logic [N-1:0] stall_req,
  output logic [N-1:0] stage_en,
  output logic [N-1:0] bubble_ins
);
  // held[k]: some stage at or beyond k is frozen, so stage k must hold
  logic [N-1:0] held;

  always_comb begin
    held[N-1] = stall_req[N-1];
    for (int k = N - 2; k >= 0; k--) begin
      held[k] = stall_req[k] | held[k+1];
    end
  end

  assign stage_en = ~held;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bub
      if (g == 0) begin : g_first
        assign bubble_ins[g] = 1'b0;
      end else begin : g_rest
        // boundary sits at g-1: previous stage held, this one free
        assign bubble_ins[g] = held[g-1] & ~held[g];
      end
    end
  endgenerate
endmodule

// File: rtl/adv_redirect_hold.sv
module adv_redirect_hold #(
  parameter int PC_W = pipe_adv_pkg::ADDR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_en,
  input  logic            redir_valid,
  input  logic [PC_W-1:0] redir_pc,
  output logic            take,
  output logic [PC_W-1:0] target,
  output logic            pend
);
  logic [PC_W-1:0] tgt_q;
  logic            pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      tgt_q  <= '0;
    end else if (fetch_en) begin
      pend_q <= 1'b0;
    end else if (redir_valid) begin
      pend_q <= 1'b1;
      tgt_q  <= redir_pc;
    end
  end

  // a fresh redirect is newer than anything held
  assign take   = redir_valid | pend_q;
  assign target = redir_valid ? redir_pc : tgt_q;
  assign pend   = pend_q;
endmodule

// File: rtl/adv_pc_seq.sv
module adv_pc_seq #(
  parameter int              PC_W     = pipe_adv_pkg::ADDR_W,
  parameter logic [PC_W-1:0] RESET_PC = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_en,
  input  logic            take,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc
);
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_inc;

  assign pc_inc = pc_q + PC_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= RESET_PC;
    end else if (fetch_en) begin
      pc_q <= take ? target : pc_inc;
    end
  end

  assign pc = pc_q;
endmodule

// File: rtl/pipe_adv_ctl.sv
module pipe_adv_ctl #(
  parameter int              NUM_STAGES = pipe_adv_pkg::STAGES,
  parameter int              PC_W       = pipe_adv_pkg::ADDR_W,
  parameter logic [PC_W-1:0] RESET_PC   = '1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_STAGES-1:0] stall_req,
  input  logic                  redirect_valid,
  input  logic [PC_W-1:0]       redirect_pc,
  output logic [NUM_STAGES-1:0] stage_en,
  output logic [NUM_STAGES-1:0] bubble_ins,
  output logic [PC_W-1:0]       fetch_pc
);
  localparam int FETCH_IDX = int'(pipe_adv_pkg::ST_FETCH);

  logic            fetch_en;
  logic            redir_take;
  logic            redir_pend;
  logic [PC_W-1:0] redir_target;

  adv_stall_boundary #(.N(NUM_STAGES)) u_boundary (
    .stall_req  (stall_req),
    .stage_en   (stage_en),
    .bubble_ins (bubble_ins)
  );

  assign fetch_en = stage_en[FETCH_IDX];

  adv_redirect_hold #(.PC_W(PC_W)) u_redir (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_en    (fetch_en),
    .redir_valid (redirect_valid),
    .redir_pc    (redirect_pc),
    .take        (redir_take),
    .target      (redir_target),
    .pend        (redir_pend)
  );

  adv_pc_seq #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .fetch_en (fetch_en),
    .take     (redir_take),
    .target   (redir_target),
    .pc       (fetch_pc)
  );
endmodule

// File: rtl/pipe_adv_ctl_chk.sv
module pipe_adv_ctl_chk #(
  parameter int N    = 5,
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    stall_req,
  input logic            redirect_valid,
  input logic [PC_W-1:0] redirect_pc,
  input logic [N-1:0]    stage_en,
  input logic [N-1:0]    bubble_ins,
  input logic [PC_W-1:0] fetch_pc,
  input logic            redir_pend
);
  AST_IDLE_ALL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_req == '0) |-> ((&stage_en) && (bubble_ins == '0))); // R1

  AST_REQUESTER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((stall_req & stage_en) == '0)); // R2

  AST_SINGLE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bubble_ins) && !bubble_ins[0]); // R4

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_en[0] && !redirect_valid && !redir_pend)
      |=> (fetch_pc == $past(fetch_pc) + 1'b1)); // R6

  AST_PC_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_en[0] && redirect_valid) |=> (fetch_pc == $past(redirect_pc))); // R7

  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !stage_en[0] |=> $stable(fetch_pc)); // R9

  genvar g;
  generate
    for (g = 0; g < N - 1; g++) begin : g_sfx
      AST_LATER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        stage_en[g] |-> stage_en[g+1]); // R3
    end
  endgenerate
endmodule

bind pipe_adv_ctl pipe_adv_ctl_chk #(.N(NUM_STAGES), .PC_W(PC_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .stall_req      (stall_req),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .stage_en       (stage_en),
  .bubble_ins     (bubble_ins),
  .fetch_pc       (fetch_pc),
  .redir_pend     (redir_pend)
);

// File: tb/pipe_adv_ctl_bench.sv
module pipe_adv_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  stall_req;
  logic        redirect_valid;
  logic [15:0] redirect_pc;
  logic [4:0]  stage_en;
  logic [4:0]  bubble_ins;
  logic [15:0] fetch_pc;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] exp_pc;
  logic        exp_pend;
  logic [15:0] exp_tgt;
  string       pc_tag;

  always #5 clk = ~clk;

  pipe_adv_ctl u_pipe_adv_ctl (
    .clk            (clk),
    .rst_n          (rst_n),
    .stall_req      (stall_req),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .stage_en       (stage_en),
    .bubble_ins     (bubble_ins),
    .fetch_pc       (fetch_pc)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // entered just after a falling edge; leaves just after the next one
  task automatic step(input logic [4:0] s, input logic rv, input logic [15:0] rp);
    logic [4:0] e_en;
    logic [4:0] e_bub;
    int         top;
    bit         fen;
    stall_req      = s;
    redirect_valid = rv;
    redirect_pc    = rp;
    #1;
    top = -1;
    for (int k = 0; k < 5; k++) if (s[k]) top = k;
    for (int k = 0; k < 5; k++) begin
      e_en[k]  = (k > top);
      e_bub[k] = (top >= 0) && (k == top + 1);
    end
    check(stage_en == e_en, (s == 0) ? "R1" : "R2/R3", "stage_en", stage_en, e_en);
    check(bubble_ins == e_bub, (s == 0) ? "R1" : "R4", "bubble_ins", bubble_ins, e_bub);
    check(fetch_pc == exp_pc, pc_tag, "fetch_pc", fetch_pc, exp_pc);
    fen = (s == 0);
    @(posedge clk);
    if (fen) begin
      if (rv) begin exp_pc = rp; pc_tag = "R7"; end
      else if (exp_pend) begin exp_pc = exp_tgt; pc_tag = "R8"; end
      else begin exp_pc = exp_pc + 16'd1; pc_tag = "R6"; end
      exp_pend = 1'b0;
    end else begin
      pc_tag = "R9";
      if (rv) begin
        if (exp_pend) pc_tag = "R10";
        exp_pend = 1'b1;
        exp_tgt  = rp;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    stall_req = '0;
    redirect_valid = 1'b0;
    redirect_pc = '0;
    exp_pc = 16'hFFFF;
    exp_pend = 1'b0;
    exp_tgt = '0;
    pc_tag = "R5";
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(fetch_pc == 16'hFFFF, "R5", "reset fetch_pc", fetch_pc, 16'hFFFF);
    // R5: a redirect during reset must not be retained afterwards
    redirect_valid = 1'b1;
    redirect_pc = 16'h7777;
    stall_req = 5'b00001;
    @(negedge clk);
    rst_n = 1'b1;
    // first advance wraps 0xFFFF to 0 (R6)
    step(5'b0, 1'b0, 16'h0);
    step(5'b0, 1'b0, 16'h0);
    // exhaustive stall sweep (R1 R2 R3 R4 R9)
    for (int s = 0; s < 32; s++) step(5'(s), 1'b0, 16'h0);
    // redirect while advancing (R7)
    step(5'b0, 1'b1, 16'h0123);
    step(5'b0, 1'b0, 16'h0);
    // redirect during fetch freeze (R8 R9)
    step(5'b00010, 1'b1, 16'h0400);
    step(5'b00010, 1'b0, 16'h0);
    step(5'b10000, 1'b0, 16'h0);
    step(5'b0, 1'b0, 16'h0);
    step(5'b0, 1'b0, 16'h0);
    // newer held redirect replaces older (R10)
    step(5'b01000, 1'b1, 16'h0AAA);
    step(5'b01000, 1'b1, 16'h0BBB);
    step(5'b0, 1'b0, 16'h0);
    step(5'b0, 1'b0, 16'h0);
    // mixed pseudo-random traffic
    for (int i = 0; i < 400; i++) begin
      logic [4:0] s;
      s = (i % 7 == 3) ? (5'b00001 << (i % 5)) : ((i % 11 == 0) ? 5'b00110 : 5'b0);
      step(s, (i % 9 == 4) || (i % 13 == 2), 16'(i * 37 + 100));
    end
    step(5'b0, 1'b0, 16'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule